// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register Block

This block holds the control and status registers for one bank of general-purpose pins. The pins are grouped into ports of eight. A 32-bit read/write bus reaches them through two address windows. The plain window gives whole-byte access to every register of a port. The alias window lets software change chosen pins of a register in a single write, with no read-modify-write. In each alias write word, the upper byte picks the pins to change and the lower byte gives their new values.

The block does not contain the pad drivers, the input synchronisers, the interrupt edge/level detector or the debouncer. It sends them the stored enable, direction, output, debounce-enable, interrupt-enable and interrupt-type vectors. It takes in the synchronised pad inputs and a per-pin event pulse from the detector. It latches those events as interrupt status and raises one summary interrupt when an enabled pin has a latched event.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, the pin enable, direction and interrupt enable vectors are all zero, no pad is driven and `irq_o` is low.
- R2: In the plain window, the byte address is group*0x10 + port*4, with groups 0 = pin enable, 1 = direction (1 = output), 2 = output value, 5 = interrupt enable and 6 = interrupt type. A write stores data bits 7:0 of the addressed port. A read returns the stored byte in bits 7:0 and zero in bits 31:8.
- R3: At `ALIAS_OFS` + group*0x10 + port*4, a write to group 0, 1, 2, 5 or 6 sets pin n to data bit n when data bit 8+n is 1. Pins whose bit 8+n is 0 keep their value. An alias read returns the same byte as the plain read.
- R4: Alias group 3 holds the per-pin debounce-enable byte, updated by the masked rule of R3 and driven on `dbc_en_o`. Plain group 3 never touches it.
- R5: A read of plain group 3 returns the `pad_in_i` byte of the port. Writes there change no register.
- R6: An `evt_i` pulse on pin n sets that pin's status bit at the next clock edge, whatever its interrupt enable. The status bit reads in group 4 of either window.
- R7: A plain group 7 write clears status bit n for each data bit n that is 1 and leaves the others. Group 7 reads as zero. An event in the same cycle as a clear wins, so the bit stays set.
- R8: An alias group 4 write sets or clears the selected status bits by the masked rule of R3.
- R9: `pad_oe_o` bit n is 1 only when both the pin enable and the direction bit of pin n are 1.
- R10: `irq_o` is high exactly when some pin has both its status bit and its interrupt enable bit at 1.
- R11: The following are reserved: an address with bits 1:0 not zero, a port index of `PORTS` or above, alias group 7, and any address outside both windows. They read as zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in_i | input | PORTS*8 | Synchronised pad input levels |
| evt_i | input | PORTS*8 | Per-pin interrupt event pulses from the detector |
| gpio_en_o | output | PORTS*8 | Pin under GPIO control |
| pad_oe_o | output | PORTS*8 | Pad output enable |
| pad_out_o | output | PORTS*8 | Pad output value |
| dbc_en_o | output | PORTS*8 | Debounce enable per pin |
| irq_en_o | output | PORTS*8 | Interrupt enable per pin |
| irq_type_o | output | PORTS*8 | Interrupt type select per pin |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench builds the block with `PORTS` = 3 and `ALIAS_OFS` = 0x200. With only three ports, port index 3 is a decodable but unpopulated slot, so the out-of-range port rule is tested inside a window. The space from 0x80 to 0x1FF then lies between the two windows, so writes that fall outside both can be shown to be dropped. Using a non-default alias base also checks that the alias window follows the parameter and not a fixed offset.

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int ADDR_W    = 12,
  parameter int PORTS     = 4,
  parameter int ALIAS_OFS = 'h080
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [PORTS*8-1:0]    pad_in_i,
  input  logic [PORTS*8-1:0]    evt_i,
  output logic [PORTS*8-1:0]    gpio_en_o,
  output logic [PORTS*8-1:0]    pad_oe_o,
  output logic [PORTS*8-1:0]    pad_out_o,
  output logic [PORTS*8-1:0]    dbc_en_o,
  output logic [PORTS*8-1:0]    irq_en_o,
  output logic [PORTS*8-1:0]    irq_type_o,
  output logic                  irq_o
);
  localparam int NP = PORTS * 8;
  localparam logic [ADDR_W-1:0] ALIAS_A = ADDR_W'(ALIAS_OFS);

  logic [NP-1:0] cfg_q, dir_q, out_q, dbc_q, sta_q, ien_q, typ_q, sta_nxt;
  logic [7:0]    rd_byte;

  wire [2:0] grp = bus_addr[6:4];
  wire [1:0] prt = bus_addr[3:2];
  wire slot_ok   = (bus_addr[1:0] == 2'b00) && (int'(prt) < PORTS);
  wire plain_hit = slot_ok && (bus_addr[ADDR_W-1:7] == '0);
  wire alias_hit = slot_ok && (bus_addr[ADDR_W-1:7] == ALIAS_A[ADDR_W-1:7]) && (grp != 3'd7);
  wire plain_we  = bus_we && plain_hit;
  wire alias_we  = bus_we && alias_hit;
  wire unused_wdata = ^bus_wdata[31:16];

  function automatic logic [7:0] mw(input logic [7:0] old, input logic [15:0] w);
    return (old & ~w[15:8]) | (w[7:0] & w[15:8]);
  endfunction

  always_comb begin
    sta_nxt = sta_q;
    for (int p = 0; p < PORTS; p++) begin
      if (prt == 2'(p)) begin
        if (plain_we && grp == 3'd7)
          sta_nxt[p*8 +: 8] = sta_q[p*8 +: 8] & ~bus_wdata[7:0];
        if (alias_we && grp == 3'd4)
          sta_nxt[p*8 +: 8] = mw(sta_q[p*8 +: 8], bus_wdata[15:0]);
      end
    end
    sta_nxt = sta_nxt | evt_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0; dir_q <= '0; out_q <= '0; dbc_q <= '0;
      sta_q <= '0; ien_q <= '0; typ_q <= '0;
    end else begin
      sta_q <= sta_nxt;
      for (int p = 0; p < PORTS; p++) begin
        if (plain_we && prt == 2'(p)) begin
          case (grp)
            3'd0: cfg_q[p*8 +: 8] <= bus_wdata[7:0];
            3'd1: dir_q[p*8 +: 8] <= bus_wdata[7:0];
            3'd2: out_q[p*8 +: 8] <= bus_wdata[7:0];
            3'd5: ien_q[p*8 +: 8] <= bus_wdata[7:0];
            3'd6: typ_q[p*8 +: 8] <= bus_wdata[7:0];
            default: ;
          endcase
        end
        if (alias_we && prt == 2'(p)) begin
          case (grp)
            3'd0: cfg_q[p*8 +: 8] <= mw(cfg_q[p*8 +: 8], bus_wdata[15:0]);
            3'd1: dir_q[p*8 +: 8] <= mw(dir_q[p*8 +: 8], bus_wdata[15:0]);
            3'd2: out_q[p*8 +: 8] <= mw(out_q[p*8 +: 8], bus_wdata[15:0]);
            3'd3: dbc_q[p*8 +: 8] <= mw(dbc_q[p*8 +: 8], bus_wdata[15:0]);
            3'd5: ien_q[p*8 +: 8] <= mw(ien_q[p*8 +: 8], bus_wdata[15:0]);
            3'd6: typ_q[p*8 +: 8] <= mw(typ_q[p*8 +: 8], bus_wdata[15:0]);
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (prt == 2'(p) && (plain_hit || alias_hit)) begin
        case (grp)
          3'd0: rd_byte = cfg_q[p*8 +: 8];
          3'd1: rd_byte = dir_q[p*8 +: 8];
          3'd2: rd_byte = out_q[p*8 +: 8];
          3'd3: rd_byte = plain_hit ? pad_in_i[p*8 +: 8] : dbc_q[p*8 +: 8];
          3'd4: rd_byte = sta_q[p*8 +: 8];
          3'd5: rd_byte = ien_q[p*8 +: 8];
          3'd6: rd_byte = typ_q[p*8 +: 8];
          default: rd_byte = '0;
        endcase
      end
    end
  end

  assign bus_rdata  = {24'h0, rd_byte};
  assign gpio_en_o  = cfg_q;
  assign pad_oe_o   = cfg_q & dir_q;
  assign pad_out_o  = out_q;
  assign dbc_en_o   = dbc_q;
  assign irq_en_o   = ien_q;
  assign irq_type_o = typ_q;
  assign irq_o      = |(sta_q & ien_q);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gpio_en_o == '0 && pad_oe_o == '0 && irq_en_o == '0 && !irq_o));

  // R6
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((sta_q & $past(evt_i)) == $past(evt_i)));

  // R7
  sta_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sta_q) & ~sta_q)) |-> $past(bus_we));

  // R11
  reserved_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !plain_hit && !alias_hit) |=>
      ($stable(gpio_en_o) && $stable(pad_oe_o) && $stable(pad_out_o) &&
       $stable(dbc_en_o) && $stable(irq_en_o) && $stable(irq_type_o)));

  for (genvar gp = 0; gp < PORTS; gp++) begin : g_port_chk
    // R3
    alias_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alias_we && grp == 3'd2 && prt == 2'(gp)) |=>
        (((pad_out_o[gp*8 +: 8] ^ $past(pad_out_o[gp*8 +: 8])) & ~$past(bus_wdata[15:8])) == 8'h00));
    // R7
    clear_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_we && grp == 3'd7 && prt == 2'(gp)) |=>
        ((sta_q[gp*8 +: 8] & $past(bus_wdata[7:0] & ~evt_i[gp*8 +: 8])) == 8'h00));
  end
endmodule

// File: tb/test_gpio_mask_bank.sv
module test_gpio_mask_bank;
  localparam int PORTS = 3;
  localparam int NP = PORTS * 8;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pad_in_i = '0, evt_i = '0;
  logic [NP-1:0] gpio_en_o, pad_oe_o, pad_out_o, dbc_en_o, irq_en_o, irq_type_o;
  logic irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_mask_bank #(.ADDR_W(12), .PORTS(PORTS), .ALIAS_OFS('h200)) i_gpio_mask_bank (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .pad_in_i, .evt_i,
    .gpio_en_o, .pad_oe_o, .pad_out_o, .dbc_en_o, .irq_en_o, .irq_type_o, .irq_o);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h000, d); check("R1 cfg read", d, 0);
    check("R1 gpio_en", 32'(gpio_en_o), 0);
    check("R1 pad_oe", 32'(pad_oe_o), 0);
    check("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_plain;
    logic [31:0] d;
    wr(12'h004, 32'hFFFF_FFA5); rd(12'h004, d); check("R2 cfg p1", d, 32'hA5);
    wr(12'h018, 32'h3C);        rd(12'h018, d); check("R2 dir p2", d, 32'h3C);
    wr(12'h020, 32'h81);        check("R2 out p0", 32'(pad_out_o[7:0]), 32'h81);
    wr(12'h060, 32'h5A);        rd(12'h060, d); check("R2 type p0", d, 32'h5A);
    check("R2 type port", 32'(irq_type_o[7:0]), 32'h5A);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    wr(12'h220, 32'h0F06); check("R3 out masked", 32'(pad_out_o[7:0]), 32'h86);
    wr(12'h204, 32'h8000); rd(12'h004, d); check("R3 cfg plain read", d, 32'h25);
    rd(12'h204, d); check("R3 cfg alias read", d, 32'h25);
  endtask

  task automatic t_dbc;
    logic [31:0] d;
    wr(12'h238, 32'hFFFF); check("R4 dbc set", 32'(dbc_en_o[23:16]), 32'hFF);
    wr(12'h238, 32'h0100); rd(12'h238, d); check("R4 dbc masked", d, 32'hFE);
    wr(12'h038, 32'h0000); check("R4 plain no effect", 32'(dbc_en_o[23:16]), 32'hFE);
  endtask

  task automatic t_input;
    logic [31:0] d;
    pad_in_i = 24'h123456;
    rd(12'h030, d); check("R5 in p0", d, 32'h56);
    rd(12'h038, d); check("R5 in p2", d, 32'h12);
    wr(12'h034, 32'hFF); rd(12'h034, d); check("R5 write ignored", d, 32'h34);
  endtask

  task automatic t_oe_gate;
    wr(12'h014, 32'hFF);
    check("R9 oe p1 gated", 32'(pad_oe_o[15:8]), 32'h25);
    check("R9 oe p2 unconfigured", 32'(pad_oe_o[23:16]), 32'h00);
  endtask

  task automatic t_status;
    logic [31:0] d;
    @(negedge clk); evt_i = 24'h000208;
    @(negedge clk); evt_i = '0;
    rd(12'h040, d); check("R6 sta p0", d, 32'h08);
    rd(12'h244, d); check("R6 sta p1 alias", d, 32'h02);
    check("R10 irq off while disabled", 32'(irq_o), 0);
    wr(12'h050, 32'h08); check("R10 irq on", 32'(irq_o), 1);
    wr(12'h070, 32'h01); rd(12'h040, d); check("R7 clear other bit", d, 32'h08);
    wr(12'h070, 32'h08); rd(12'h040, d); check("R7 clear hit", d, 32'h00);
    check("R10 irq off after clear", 32'(irq_o), 0);
    rd(12'h070, d); check("R7 clear reads zero", d, 0);
    @(negedge clk); bus_we = 1; bus_addr = 12'h070; bus_wdata = 32'h08; evt_i = 24'h000008;
    @(negedge clk); bus_we = 0; evt_i = '0;
    rd(12'h040, d); check("R7 event wins", d, 32'h08);
  endtask

  task automatic t_alias_status;
    logic [31:0] d;
    wr(12'h244, 32'h0303); rd(12'h044, d); check("R8 alias set", d, 32'h03);
    wr(12'h244, 32'h0200); rd(12'h044, d); check("R8 alias clear", d, 32'h01);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(12'h00C, 32'hFF); rd(12'h00C, d); check("R11 port3 read", d, 0);
    check("R11 port3 write", 32'(gpio_en_o), 32'h002500);
    wr(12'h100, 32'hFF); rd(12'h100, d); check("R11 gap read", d, 0);
    wr(12'h001, 32'hFF); rd(12'h000, d); check("R11 misaligned", d, 0);
    wr(12'h270, 32'hFFFF); rd(12'h270, d); check("R11 alias grp7 read", d, 0);
    rd(12'h044, d); check("R11 alias grp7 write", d, 32'h01);
    check("R11 outputs kept", 32'(pad_out_o), 32'h000086);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_plain();
    t_alias();
    t_dbc();
    t_input();
    t_oe_gate();
    t_status();
    t_alias_status();
    t_reserved();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule